// File: doc/BRIEF.md
# Receive Sampling Delay Search Engine

This block picks the receive sampling delay for a high-speed memory card link without software stepping it. Once started, it walks a tap index upward through a fixed window. For each tap it loads the value onto the delay-line control bus and raises an update flag. The delay line lowers that flag by acknowledging once the new delay has settled. The engine then asks an external command sequencer for one tuning-block transfer and receives a pass or fail verdict.

While the sweep runs, the engine keeps two counts. One is the number of consecutive passing taps ending at the current tap. The other is the longest such run seen so far, stored together with the tap where that run ended. After the last tap, the engine loads the middle of the best run through the same update handshake and raises `done`. If no tap passed, or the final update is never acknowledged, `done` comes with `err`.

A start request is accepted only while the link runs in its high-speed eMMC timing mode, where the dedicated tuning command exists. In any other mode the request is refused with a one-cycle pulse.

Top module: `rx_tap_search`

## Requirements
- R1: An accepted start tries taps 0 through TAP_COUNT-1 (default 40, of a 6-bit field) in ascending order. Each try raises `tuneUpdFlag` once, and `tapValue` carries the tap under test from that rise onward.
- R2: After raising `tuneUpdFlag`, the engine does not assert `xferReq` until `updAck` has been seen. The flag drops on the cycle after `updAck`.
- R3: If `updAck` does not arrive within UPD_TIMEOUT cycles (default 8), the flag drops, no transfer is requested for that tap, and the tap counts as a failure.
- R4: A `xferDone` pulse with `xferOk`=1 extends the current run by one. With `xferOk`=0 it resets the current run to zero.
- R5: The best run is the longest run of passing taps. Among runs of equal length, the earliest one is kept.
- R6: After the sweep, `tapValue` is loaded with the best run's last tap minus floor(run length / 2), and `tuneUpdFlag` is raised one more time. `done` rises only after that update is acknowledged, with `err`=0.
- R7: If no tap passed, `done` and `err` rise without a final update. `tuneUpdFlag` is raised exactly TAP_COUNT times, and `tapValue` keeps the last tap tried.
- R8: `startReq` with `modeOk`=0 while idle produces a one-cycle `startRej` pulse. `busy` stays 0, and `done`/`err` keep their values.
- R9: `startReq` while `busy` is ignored. The running sweep completes with the same trial count and result.
- R10: If the final update is not acknowledged within UPD_TIMEOUT cycles, the flag drops and `done` and `err` rise together.
- R11: After reset, `busy`, `done`, `err`, `tuneUpdFlag`, `xferReq` and `startRej` are 0 and `tapValue` is 0.
- R12: An accepted start clears `done`, `err` and all run counts, so a sweep's result does not depend on earlier sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a sweep |
| modeOk | input | 1 | High when the link is in the high-speed eMMC timing mode |
| tapValue | output | TAP_W | Delay value driven to the delay line |
| tuneUpdFlag | output | 1 | Update pending; lowered on acknowledge or timeout |
| updAck | input | 1 | Delay line reports the new value in effect |
| xferReq | output | 1 | One-cycle request for a tuning-block transfer |
| xferDone | input | 1 | One-cycle transfer completion |
| xferOk | input | 1 | Transfer result, valid with xferDone |
| busy | output | 1 | Sweep or final update in progress |
| done | output | 1 | Search finished (level, held until next accepted start) |
| err | output | 1 | No passing tap, or final update unacknowledged |
| startRej | output | 1 | One-cycle pulse on a refused start |

## Verification
The hardest cases to reach from the ports are a tap whose update is never acknowledged and a final update that times out. Both take a responder that withholds acknowledges selectively. The bench models the delay line and the transfer sequencer with a per-tap pass mask, a per-tap no-acknowledge mask and a final-update switch. These drive the timeout path mid-sweep and at the end, and the bench computes the expected centre from the masks. Equal-length runs, a run that reaches the last tap, isolated single passes and a restart attempt in the middle of a sweep cover the streak bookkeeping and start filtering.

// File: rtl/rx_tap_pkg.sv
package rx_tap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_WAIT_UPD,
    ST_XFER,
    ST_WAIT_XFER,
    ST_NEXT,
    ST_FINAL,
    ST_FINAL_WAIT
  } tapState_t;

  typedef struct packed {
    logic clrAll;
    logic loadTrial;
    logic recPass;
    logic recFail;
    logic nextIdx;
    logic loadFinal;
  } dpCtl_t;

endpackage

// File: rtl/rx_tap_dp.sv
module rx_tap_dp
  import rx_tap_pkg::*;
#(
  parameter int TAP_W     = 6,
  parameter int TAP_COUNT = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  output logic [TAP_W-1:0] tapValue,
  output logic             lastIdx,
  output logic             anyPass
);

  localparam int LEN_W = $clog2(TAP_COUNT + 1);
  localparam int SUM_W = (LEN_W > TAP_W) ? LEN_W : TAP_W;

  logic [TAP_W-1:0] idx;
  logic [TAP_W-1:0] tapReg;
  logic [TAP_W-1:0] bestEnd;
  logic [LEN_W-1:0] curLen;
  logic [LEN_W-1:0] bestLen;
  logic [LEN_W-1:0] curInc;
  logic [SUM_W-1:0] centre;

  assign curInc  = curLen + LEN_W'(1);
  assign centre  = SUM_W'(bestEnd) - SUM_W'(bestLen >> 1);
  assign lastIdx = (idx == TAP_W'(TAP_COUNT - 1));
  assign anyPass = (bestLen != '0);
  assign tapValue = tapReg;

  // sweep index
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll) idx <= '0;
    else if (ctl.nextIdx)    idx <= idx + TAP_W'(1);
  end

  // streak bookkeeping: only a strictly longer run replaces the best one
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll) begin
      curLen  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else if (ctl.recPass) begin
      curLen <= curInc;
      if (curInc > bestLen) begin
        bestLen <= curInc;
        bestEnd <= idx;
      end
    end else if (ctl.recFail) begin
      curLen <= '0;
    end
  end

  // value driven to the delay line
  always_ff @(posedge clk) begin
    if (!rstN)              tapReg <= '0;
    else if (ctl.loadTrial) tapReg <= idx;
    else if (ctl.loadFinal) tapReg <= centre[TAP_W-1:0];
  end

  AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    idx < TAP_W'(TAP_COUNT)); // R1
  AST_CUR_NOT_ABOVE_BEST: assert property (@(posedge clk) disable iff (!rstN)
    curLen <= bestLen); // R5
  AST_PASS_GROWS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.recPass && !ctl.clrAll) |=> curLen == $past(curLen) + LEN_W'(1)); // R4
  AST_FAIL_ZEROES_RUN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.recFail |=> curLen == '0); // R4
  AST_TAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    tapReg < TAP_W'(TAP_COUNT)); // R6

endmodule

// File: rtl/rx_tap_ctrl.sv
module rx_tap_ctrl
  import rx_tap_pkg::*;
#(
  parameter int UPD_TIMEOUT = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   modeOk,
  input  logic   updAck,
  input  logic   xferDone,
  input  logic   xferOk,
  input  logic   lastIdx,
  input  logic   anyPass,
  output dpCtl_t ctl,
  output logic   updFlag,
  output logic   xferReq,
  output logic   busy,
  output logic   done,
  output logic   err,
  output logic   startRej
);

  localparam int TMR_W = $clog2(UPD_TIMEOUT + 1);

  tapState_t st, stNext;
  logic [TMR_W-1:0] timer;
  logic timerExp;
  logic inWait;
  logic flagSet;

  assign timerExp = (timer == TMR_W'(UPD_TIMEOUT - 1));
  assign inWait   = (st == ST_WAIT_UPD) || (st == ST_FINAL_WAIT);
  assign flagSet  = (st == ST_APPLY) || (st == ST_FINAL && anyPass);
  assign busy     = (st != ST_IDLE);
  assign xferReq  = (st == ST_XFER);

  always_comb begin
    ctl    = '0;
    stNext = st;
    case (st)
      ST_IDLE: begin
        if (startReq && modeOk) begin
          ctl.clrAll = 1'b1;
          stNext     = ST_APPLY;
        end
      end
      ST_APPLY: begin
        ctl.loadTrial = 1'b1;
        stNext        = ST_WAIT_UPD;
      end
      ST_WAIT_UPD: begin
        if (updAck) begin
          stNext = ST_XFER;
        end else if (timerExp) begin
          ctl.recFail = 1'b1;
          stNext      = ST_NEXT;
        end
      end
      ST_XFER: stNext = ST_WAIT_XFER;
      ST_WAIT_XFER: begin
        if (xferDone) begin
          ctl.recPass = xferOk;
          ctl.recFail = !xferOk;
          stNext      = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (lastIdx) begin
          stNext = ST_FINAL;
        end else begin
          ctl.nextIdx = 1'b1;
          stNext      = ST_APPLY;
        end
      end
      ST_FINAL: begin
        if (anyPass) begin
          ctl.loadFinal = 1'b1;
          stNext        = ST_FINAL_WAIT;
        end else begin
          stNext = ST_IDLE;
        end
      end
      ST_FINAL_WAIT: begin
        if (updAck || timerExp) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  // update flag and its acknowledge timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      updFlag <= 1'b0;
      timer   <= '0;
    end else if (flagSet) begin
      updFlag <= 1'b1;
      timer   <= '0;
    end else if (inWait) begin
      if (updAck || timerExp) begin
        updFlag <= 1'b0;
        timer   <= '0;
      end else begin
        timer <= timer + TMR_W'(1);
      end
    end
  end

  // completion status, held until the next accepted start
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrAll) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else if (st == ST_FINAL && !anyPass) begin
      done <= 1'b1;
      err  <= 1'b1;
    end else if (st == ST_FINAL_WAIT && (updAck || timerExp)) begin
      done <= 1'b1;
      err  <= !updAck;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) startRej <= 1'b0;
    else       startRej <= (st == ST_IDLE) && startReq && !modeOk;
  end

  AST_XFER_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |-> !updFlag); // R2
  AST_ACK_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (updFlag && updAck && inWait) |=> !updFlag); // R2
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timer < TMR_W'(UPD_TIMEOUT)); // R3
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !updFlag)); // R6
  AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    startRej |-> !busy); // R8
  AST_REJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startRej |=> !startRej || $past(startReq)); // R8

endmodule

// File: rtl/rx_tap_search.sv
module rx_tap_search
  import rx_tap_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int TAP_COUNT   = 40,
  parameter int UPD_TIMEOUT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             modeOk,
  output logic [TAP_W-1:0] tapValue,
  output logic             tuneUpdFlag,
  input  logic             updAck,
  output logic             xferReq,
  input  logic             xferDone,
  input  logic             xferOk,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             startRej
);

  dpCtl_t ctl;
  logic   lastIdx;
  logic   anyPass;

  rx_tap_ctrl #(
    .UPD_TIMEOUT(UPD_TIMEOUT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .modeOk   (modeOk),
    .updAck   (updAck),
    .xferDone (xferDone),
    .xferOk   (xferOk),
    .lastIdx  (lastIdx),
    .anyPass  (anyPass),
    .ctl      (ctl),
    .updFlag  (tuneUpdFlag),
    .xferReq  (xferReq),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .startRej (startRej)
  );

  rx_tap_dp #(
    .TAP_W     (TAP_W),
    .TAP_COUNT (TAP_COUNT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .tapValue (tapValue),
    .lastIdx  (lastIdx),
    .anyPass  (anyPass)
  );

endmodule

// File: tb/rx_tap_search_tb_top.sv
module rx_tap_search_tb_top;

  localparam int NT = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       modeOk = 1'b1;
  logic [5:0] tapValue;
  logic       tuneUpdFlag;
  logic       updAck;
  logic       xferReq;
  logic       xferDone;
  logic       xferOk;
  logic       busy, done, err, startRej;

  always #2.5 clk = ~clk;

  rx_tap_search dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeOk(modeOk),
    .tapValue(tapValue), .tuneUpdFlag(tuneUpdFlag), .updAck(updAck),
    .xferReq(xferReq), .xferDone(xferDone), .xferOk(xferOk),
    .busy(busy), .done(done), .err(err), .startRej(startRej)
  );

  int checks = 0;
  int errors = 0;

  logic [NT-1:0] passMask = '0;
  logic [NT-1:0] noAckMask = '0;
  logic          finalNoAck = 1'b0;

  int flagRises, xferCount, seqErr, overlap;
  int ackCnt, xferWait, xferTap;
  logic ackGiven, prevFlag, curFinal;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // delay line and transfer sequencer model
  initial begin
    updAck = 0; xferDone = 0; xferOk = 0;
    prevFlag = 0; ackGiven = 0; ackCnt = 0; xferWait = 0; xferTap = 0; curFinal = 0;
    forever begin
      @(negedge clk);
      updAck = 0; xferDone = 0; xferOk = 0;
      if (rstN) begin
        if (tuneUpdFlag && !prevFlag) begin
          flagRises++;
          ackCnt = 0; ackGiven = 0;
          curFinal = (flagRises > NT);
          if (!curFinal && int'(tapValue) != flagRises - 1) seqErr++;
        end
        if (tuneUpdFlag && !ackGiven) begin
          ackCnt++;
          if (ackCnt == 2) begin
            if (curFinal ? !finalNoAck : !noAckMask[tapValue]) begin
              updAck = 1; ackGiven = 1;
            end
          end
        end
        if (tuneUpdFlag && done) overlap++;
        prevFlag = tuneUpdFlag;
        if (xferWait > 0) begin
          xferWait--;
          if (xferWait == 0) begin
            xferDone = 1; xferOk = passMask[xferTap];
          end
        end
        if (xferReq) begin
          xferCount++;
          if (tuneUpdFlag) overlap++;
          xferTap = int'(tapValue);
          xferWait = 2;
        end
      end
    end
  end

  function automatic logic [NT-1:0] runOf(input int lo, input int hi);
    logic [NT-1:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  // expected centre: scan every start point, keep strictly longer runs only
  function automatic int expCentre(input logic [NT-1:0] eff, output int bestLen);
    int bestStart = 0;
    bestLen = 0;
    for (int s = 0; s < NT; s++) begin
      int len = 0;
      while (s + len < NT && eff[s + len]) len++;
      if (len > bestLen) begin bestLen = len; bestStart = s; end
    end
    return (bestStart + bestLen - 1) - bestLen / 2;
  endfunction

  task automatic runSweep(input logic [NT-1:0] pm, input logic [NT-1:0] nm,
                          input logic fna, input logic midStart, input string tag);
    int bl, expV, expFlags, skipped;
    logic expErr;
    passMask = pm; noAckMask = nm; finalNoAck = fna;
    flagRises = 0; xferCount = 0; seqErr = 0; overlap = 0;
    expV = expCentre(pm & ~nm, bl);
    skipped = $countones(nm);
    expFlags = NT + ((bl > 0) ? 1 : 0);
    expErr = (bl == 0) || fna;
    if (bl == 0) expV = NT - 1;
    @(negedge clk); modeOk = 1; startReq = 1;
    @(negedge clk); startReq = 0;
    chk(busy == 1'b1 && done == 1'b0 && err == 1'b0, {tag, " R12 start clears status"},
        {busy, done, err}, 3'b100);
    if (midStart) begin
      while (flagRises < 10) @(negedge clk);
      startReq = 1;
      @(negedge clk); startReq = 0;
    end
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    chk(done == 1'b1, {tag, " R6 done"}, done, 1);
    chk(busy == 1'b0 && tuneUpdFlag == 1'b0, {tag, " R6 idle after done"}, {busy, tuneUpdFlag}, 0);
    chk(err == expErr, {tag, " R7 R10 err"}, err, expErr);
    chk(int'(tapValue) == expV, {tag, " R5 R6 final tap"}, tapValue, expV);
    chk(flagRises == expFlags, {tag, " R1 R7 update count"}, flagRises, expFlags);
    chk(xferCount == NT - skipped, {tag, " R3 transfer count"}, xferCount, NT - skipped);
    chk(seqErr == 0, {tag, " R1 tap order"}, seqErr, 0);
    chk(overlap == 0, {tag, " R2 R6 handshake order"}, overlap, 0);
    if (midStart) chk(flagRises == expFlags, {tag, " R9 restart ignored"}, flagRises, expFlags);
  endtask

  initial begin
    logic [NT-1:0] alt;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk({busy, done, err, tuneUpdFlag, xferReq, startRej} == 6'b0, "R11 reset outputs",
        {busy, done, err, tuneUpdFlag, xferReq, startRej}, 0);
    chk(tapValue == 6'd0, "R11 reset tap", tapValue, 0);

    // refused start in a foreign mode
    modeOk = 0; startReq = 1;
    @(negedge clk); startReq = 0; modeOk = 1;
    chk(startRej == 1'b1 && busy == 1'b0, "R8 reject pulse", {startRej, busy}, 2'b10);
    @(negedge clk);
    chk(startRej == 1'b0 && busy == 1'b0, "R8 reject one cycle", {startRej, busy}, 0);

    runSweep('1, '0, 0, 0, "allpass");
    runSweep('0, '0, 0, 0, "nopass");
    runSweep(runOf(7, 7), '0, 0, 0, "single7");
    runSweep(runOf(3, 6) | runOf(20, 23), '0, 0, 0, "tie");
    runSweep(runOf(2, 4) | runOf(10, 17), '0, 0, 0, "longerlater");
    runSweep(runOf(35, 39) | runOf(0, 1), '0, 0, 0, "tailrun");
    alt = '0;
    for (int i = 0; i < NT; i += 2) alt[i] = 1'b1;
    runSweep(alt, '0, 0, 0, "alternate");
    runSweep('1, runOf(20, 20), 0, 0, "ackmiss20");
    runSweep(runOf(5, 30), '0, 0, 1, "restart");
    runSweep('1, '0, 1, 0, "finaltimeout");

    // refusal after completion leaves status alone
    modeOk = 0; startReq = 1;
    @(negedge clk); startReq = 0; modeOk = 1;
    chk(startRej && done && err && !busy, "R8 status kept", {startRej, done, err, busy}, 4'b1110);

    runSweep(runOf(0, 9) | runOf(12, 39), '0, 0, 0, "aftererr");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule